// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block turns high-level flash requests into the ordered series of 16-bit register accesses that a common-flash-interface NOR device expects. A request names one of eight operations with a 3-bit opcode, a target address, up to 32 bits of write data and a width flag. The sequencer then issues command writes, data writes, data reads and status polls on a simple request/acknowledge register port. It returns any read data and a timeout flag on a response channel. Programming and erasing end with a status-poll loop that repeats until the device reports ready, or until a parameterised number of polls has been spent.

Requests arrive on a valid/ready channel. `cmd_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Results leave on a second valid/ready channel. `rsp_valid` stays high with `rsp_data` and `rsp_timeout` frozen until the consumer raises `rsp_ready`, so a stalled consumer back-pressures the whole block: no new request is taken until the response has been delivered. `busy` and `status_q` are plain status pins. `status_q` holds the low byte of the most recent status word read from the device.

Opcode encoding: 0 program, 1 unlock-and-erase, 2 read array, 3 read status, 4 clear status, 5 read identifier, 6 query, 7 no operation. `cmd_wide` selects 32-bit transfers for program and read array.

Top module: `fseq_top`

## Requirements
- R1: After reset and between operations, `cmd_ready` is 1 and `busy` is 0. A request is taken on an edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `busy` is 1 and `cmd_ready` is 0 until the response has been taken.
- R2: A register access holds `bus_req` with stable `bus_we`, `bus_addr` and `bus_wdata` until a cycle in which `bus_ack` is 1. That cycle completes the access. Only one access is outstanding at a time.
- R3: Program (opcode 0, narrow) writes 0x0040 to the target address, then writes `cmd_wdata[15:0]` to the same address, then polls status.
- R4: A status poll writes 0x0070 to address 0 and then reads address 0, repeating the pair until bit 7 of the read word is 1. Every status word read (poll or opcode 3) loads its low byte into `status_q`, and no other event changes `status_q`.
- R5: A wide program first programs `cmd_wdata[31:16]` at the address, with its own poll, and then programs `cmd_wdata[15:0]` at address+2 (modulo the address width).
- R6: Unlock-and-erase (opcode 1) writes 0x0060, 0x00D0, 0x0020 and 0x00D0, in that order, to the target address, then polls status.
- R7: Read array (opcode 2) writes 0x00FF to the address and then reads it. When wide, it repeats this at address+2. `rsp_data` is the first word in bits 31:16 and the second in bits 15:0. A narrow read returns the word in bits 15:0 with zeros above.
- R8: Read status (opcode 3) writes 0x0070 to address 0 and reads address 0 once, with no repeat. `rsp_data` is the 16-bit word zero-extended.
- R9: Clear status (opcode 4) writes 0x0050 to address 0 and makes no other access.
- R10: Read identifier (opcode 5) writes 0x0090 to address 0, and query (opcode 6) writes 0x0098 to address 0. Each then reads at the address input shifted left by one bit, with the input taken as a word index, and returns the word zero-extended.
- R11: If `MAX_POLLS` status reads in a row show bit 7 clear, the operation stops at once with `rsp_timeout` 1 and makes no further access, so a wide program skips its second half. All other responses carry `rsp_timeout` 0.
- R12: Opcode 7 makes no bus access and answers with `rsp_data` 0.
- R13: `rsp_data` is 0 for program, erase and clear status. A response stays valid and unchanged until `rsp_ready` is 1.
- R14: During reset and right after it, `bus_req`, `rsp_valid` and `busy` are 0 and `status_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer can take a request |
| cmd_op | input | 3 | Operation code |
| cmd_wide | input | 1 | 32-bit transfer for program/read |
| cmd_addr | input | AW | Byte address, or word index for identifier/query |
| cmd_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Returned data |
| rsp_timeout | output | 1 | Ready was not seen within the poll limit |
| busy | output | 1 | Operation in progress |
| status_q | output | 8 | Low byte of the last status word read |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 16 | Write word |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 16 | Read word, valid with `bus_ack` |

## Verification
The bench goes after poll-loop boundaries. It makes the device report ready exactly on the last allowed poll, which a design with an off-by-one limit would report as a timeout. It also withholds ready for one poll more than allowed, which a design without the limit would answer by polling forever. A timeout in the first half of a wide program is aimed at a design that goes on to the second half. A wide read at the top of the address space checks the wrap to address+2 and the order of the halves, which a design that swaps halves or forgets the increment would get wrong. Random acknowledge latency and a stalled response consumer expose a design that lets the bus fields or the held response drift before the handshake completes.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [2:0] {
    OP_PROG    = 3'd0,
    OP_ERASE   = 3'd1,
    OP_READ    = 3'd2,
    OP_RDSTAT  = 3'd3,
    OP_CLRSTAT = 3'd4,
    OP_IDENT   = 3'd5,
    OP_QUERY   = 3'd6,
    OP_NOP     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_WRITE,
    K_READ,
    K_POLL,
    K_END
  } kind_e;

  typedef enum logic [1:0] {
    A_TARGET,
    A_ZERO,
    A_IDENT
  } asel_e;

  typedef struct packed {
    kind_e       kind;
    asel_e       asel;
    logic        use_data;
    logic        stat_cap;
    logic [15:0] word;
  } step_t;

  localparam logic [15:0] CW_PROGRAM = 16'h0040;
  localparam logic [15:0] CW_UNLOCK  = 16'h0060;
  localparam logic [15:0] CW_CONFIRM = 16'h00D0;
  localparam logic [15:0] CW_ERASE   = 16'h0020;
  localparam logic [15:0] CW_ARRAY   = 16'h00FF;
  localparam logic [15:0] CW_STATUS  = 16'h0070;
  localparam logic [15:0] CW_CLEAR   = 16'h0050;
  localparam logic [15:0] CW_IDENT   = 16'h0090;
  localparam logic [15:0] CW_QUERY   = 16'h0098;

endpackage

// File: rtl/fseq_step_decode.sv
module fseq_step_decode
  import fseq_pkg::*;
#(
  parameter int SW = 3
) (
  input  op_e           op,
  input  logic [SW-1:0] step,
  output step_t         st
);

  function automatic step_t s_wr(asel_e a, logic [15:0] w);
    step_t r;
    r.kind = K_WRITE; r.asel = a; r.use_data = 1'b0; r.stat_cap = 1'b0; r.word = w;
    return r;
  endfunction

  function automatic step_t s_wd();
    step_t r;
    r.kind = K_WRITE; r.asel = A_TARGET; r.use_data = 1'b1; r.stat_cap = 1'b0; r.word = 16'h0;
    return r;
  endfunction

  function automatic step_t s_rd(asel_e a, logic cap);
    step_t r;
    r.kind = K_READ; r.asel = a; r.use_data = 1'b0; r.stat_cap = cap; r.word = 16'h0;
    return r;
  endfunction

  function automatic step_t s_kind(kind_e k);
    step_t r;
    r.kind = k; r.asel = A_ZERO; r.use_data = 1'b0; r.stat_cap = 1'b0; r.word = 16'h0;
    return r;
  endfunction

  always_comb begin
    st = s_kind(K_END);
    case (op)
      OP_PROG: begin
        case (step)
          SW'(0):  st = s_wr(A_TARGET, CW_PROGRAM);
          SW'(1):  st = s_wd();
          SW'(2):  st = s_kind(K_POLL);
          default: st = s_kind(K_END);
        endcase
      end
      OP_ERASE: begin
        case (step)
          SW'(0):  st = s_wr(A_TARGET, CW_UNLOCK);
          SW'(1):  st = s_wr(A_TARGET, CW_CONFIRM);
          SW'(2):  st = s_wr(A_TARGET, CW_ERASE);
          SW'(3):  st = s_wr(A_TARGET, CW_CONFIRM);
          SW'(4):  st = s_kind(K_POLL);
          default: st = s_kind(K_END);
        endcase
      end
      OP_READ: begin
        case (step)
          SW'(0):  st = s_wr(A_TARGET, CW_ARRAY);
          SW'(1):  st = s_rd(A_TARGET, 1'b0);
          default: st = s_kind(K_END);
        endcase
      end
      OP_RDSTAT: begin
        case (step)
          SW'(0):  st = s_wr(A_ZERO, CW_STATUS);
          SW'(1):  st = s_rd(A_ZERO, 1'b1);
          default: st = s_kind(K_END);
        endcase
      end
      OP_CLRSTAT: begin
        case (step)
          SW'(0):  st = s_wr(A_ZERO, CW_CLEAR);
          default: st = s_kind(K_END);
        endcase
      end
      OP_IDENT, OP_QUERY: begin
        case (step)
          SW'(0):  st = s_wr(A_ZERO, (op == OP_IDENT) ? CW_IDENT : CW_QUERY);
          SW'(1):  st = s_rd(A_IDENT, 1'b0);
          default: st = s_kind(K_END);
        endcase
      end
      default: st = s_kind(K_END);
    endcase
  end

endmodule

// File: rtl/fseq_bus_if.sv
module fseq_bus_if #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  output logic          done
);

  assign done = bus_req & bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (go) begin
      bus_req   <= 1'b1;
      bus_we    <= go_we;
      bus_addr  <= go_addr;
      bus_wdata <= go_wdata;
    end else if (bus_ack) begin
      bus_req   <= 1'b0;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  // R2
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !bus_req || bus_ack);

endmodule

// File: rtl/fseq_poll_ctr.sv
module fseq_poll_ctr #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int CW = $clog2(MAX_POLLS + 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + CW'(1);
  end

  // R11
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last);

endmodule

// File: rtl/fseq_top.sv
module fseq_top
  import fseq_pkg::*;
#(
  parameter int AW        = 24,
  parameter int MAX_POLLS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_wide,
  input  logic [AW-1:0] cmd_addr,
  input  logic [31:0]   cmd_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_data,
  output logic          rsp_timeout,
  output logic          busy,
  output logic [7:0]    status_q,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [15:0]   bus_wdata,
  input  logic          bus_ack,
  input  logic [15:0]   bus_rdata
);

  localparam int SW       = 3;
  localparam int READY_BIT = 7;

  typedef enum logic [2:0] {S_IDLE, S_DISP, S_WAIT, S_PW, S_PR, S_RESP} state_e;

  state_e        state;
  op_e           op_q;
  logic          wide_q;
  logic          half_q;
  logic [SW-1:0] step_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q;
  logic [31:0]   data_q;
  logic          to_q;
  logic [7:0]    stat_q;

  step_t         st;
  logic          go, go_we, done, last;
  logic [AW-1:0] go_addr, tgt_addr, acc_addr;
  logic [15:0]   go_wdata, prog_word;
  logic          split_wide, poll_clr, poll_inc, ready_seen;

  fseq_step_decode #(.SW(SW)) u_dec (
    .op   (op_q),
    .step (step_q),
    .st   (st)
  );

  fseq_bus_if #(.AW(AW), .DW(16)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_we     (go_we),
    .go_addr   (go_addr),
    .go_wdata  (go_wdata),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done)
  );

  fseq_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .inc   (poll_inc),
    .last  (last)
  );

  assign cmd_ready   = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign rsp_valid   = (state == S_RESP);
  assign rsp_data    = data_q;
  assign rsp_timeout = to_q;
  assign status_q    = stat_q;

  assign split_wide = wide_q && (op_q == OP_PROG || op_q == OP_READ);
  assign tgt_addr   = half_q ? addr_q + AW'(2) : addr_q;
  assign prog_word  = (wide_q && !half_q) ? wdata_q[31:16] : wdata_q[15:0];
  assign ready_seen = bus_rdata[READY_BIT];

  always_comb begin
    case (st.asel)
      A_TARGET: acc_addr = tgt_addr;
      A_IDENT:  acc_addr = addr_q << 1;
      default:  acc_addr = '0;
    endcase
  end

  assign poll_clr = (state == S_DISP) && (st.kind == K_POLL);
  assign poll_inc = (state == S_PR) && done && !ready_seen && !last;

  always_comb begin
    go       = 1'b0;
    go_we    = 1'b0;
    go_addr  = '0;
    go_wdata = '0;
    case (state)
      S_DISP: begin
        case (st.kind)
          K_WRITE: begin
            go       = 1'b1;
            go_we    = 1'b1;
            go_addr  = acc_addr;
            go_wdata = st.use_data ? prog_word : st.word;
          end
          K_READ: begin
            go      = 1'b1;
            go_addr = acc_addr;
          end
          K_POLL: begin
            go       = 1'b1;
            go_we    = 1'b1;
            go_wdata = CW_STATUS;
          end
          default: ;
        endcase
      end
      S_PW: go = done;
      S_PR: begin
        if (poll_inc) begin
          go       = 1'b1;
          go_we    = 1'b1;
          go_wdata = CW_STATUS;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_NOP;
      wide_q  <= 1'b0;
      half_q  <= 1'b0;
      step_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      data_q  <= '0;
      to_q    <= 1'b0;
      stat_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q    <= op_e'(cmd_op);
            wide_q  <= cmd_wide;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
            half_q  <= 1'b0;
            step_q  <= '0;
            data_q  <= '0;
            to_q    <= 1'b0;
            state   <= S_DISP;
          end
        end
        S_DISP: begin
          case (st.kind)
            K_END: begin
              if (split_wide && !half_q) begin
                half_q <= 1'b1;
                step_q <= '0;
              end else begin
                state <= S_RESP;
              end
            end
            K_POLL:  state <= S_PW;
            default: state <= S_WAIT;
          endcase
        end
        S_WAIT: begin
          if (done) begin
            if (st.kind == K_READ) data_q <= {data_q[15:0], bus_rdata};
            if (st.stat_cap)       stat_q <= bus_rdata[7:0];
            step_q <= step_q + SW'(1);
            state  <= S_DISP;
          end
        end
        S_PW: if (done) state <= S_PR;
        S_PR: begin
          if (done) begin
            stat_q <= bus_rdata[7:0];
            if (ready_seen) begin
              step_q <= step_q + SW'(1);
              state  <= S_DISP;
            end else if (last) begin
              to_q  <= 1'b1;
              state <= S_RESP;
            end else begin
              state <= S_PW;
            end
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready);

  // R13
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_timeout));

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !rsp_valid);

  // R4
  status_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_ack && !bus_we) |=> $stable(status_q));

  // R11
  timeout_notready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> !status_q[7]);

endmodule

// File: tb/fseq_top_bench.sv
`timescale 1ns/1ps
module fseq_top_bench;

  localparam int AW   = 24;
  localparam int MAXP = 4;
  localparam logic [AW-1:0] AMASK = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_ready, cmd_wide = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0]   cmd_wdata = '0;
  logic          rsp_valid, rsp_ready = 1'b0, rsp_timeout, busy;
  logic [31:0]   rsp_data;
  logic [7:0]    status_q;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [15:0]   bus_wdata;
  logic          bus_ack;
  logic [15:0]   bus_rdata;

  fseq_top #(.AW(AW), .MAX_POLLS(MAXP)) u_fseq_top (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_wide(cmd_wide),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .busy(busy), .status_q(status_q),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // ---------------- device model ----------------
  logic          ack_r = 1'b0;
  logic [15:0]   rd_r = '0;
  int            wait_cnt = 0;
  int            lat_knob = 0;
  int            b_knob = 0;
  logic [6:0]    low_knob = '0;
  logic          clr_log = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [7:0]    idcmd = 8'h90;
  int            countdown = 0;
  logic          pend_data = 1'b0, erase_arm = 1'b0;
  logic [AW+16:0] log_e [0:63];
  int            log_n = 0;
  int            r2_err = 0;
  logic          prev_pend = 1'b0;
  logic [AW+16:0] prev_f = '0;

  assign bus_ack   = ack_r;
  assign bus_rdata = rd_r;

  function automatic logic [15:0] arr_val(logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  always @(posedge clk) begin
    prev_pend <= bus_req && !bus_ack;
    prev_f    <= {bus_we, bus_addr, bus_wdata};
    if (prev_pend && (!bus_req || prev_f != {bus_we, bus_addr, bus_wdata})) r2_err <= r2_err + 1;
    if (!rst_n) begin
      ack_r <= 1'b0; wait_cnt <= 0; log_n <= 0; countdown <= 0;
      pend_data <= 1'b0; erase_arm <= 1'b0; mode <= 2'd0;
    end else if (clr_log) begin
      log_n <= 0; countdown <= 0; pend_data <= 1'b0; erase_arm <= 1'b0;
    end else if (ack_r) begin
      ack_r <= 1'b0;
    end else if (bus_req) begin
      if (wait_cnt != 0) wait_cnt <= wait_cnt - 1;
      else begin
        if (log_n < 64) log_e[log_n] <= {bus_we, bus_addr, bus_we ? bus_wdata : 16'h0};
        log_n    <= log_n + 1;
        ack_r    <= 1'b1;
        wait_cnt <= int'($urandom % (lat_knob + 1));
        if (bus_we) begin
          if (pend_data) begin
            pend_data <= 1'b0; countdown <= b_knob;
          end else begin
            if (erase_arm) begin
              erase_arm <= 1'b0;
              if (bus_wdata == 16'h00D0) countdown <= b_knob;
            end else if (bus_wdata == 16'h0040) pend_data <= 1'b1;
            else if (bus_wdata == 16'h0020) erase_arm <= 1'b1;
            if (bus_wdata == 16'h0070) mode <= 2'd1;
            if (bus_wdata == 16'h00FF) mode <= 2'd0;
            if (bus_wdata == 16'h0090 || bus_wdata == 16'h0098) begin
              mode <= 2'd2; idcmd <= bus_wdata[7:0];
            end
          end
        end else begin
          case (mode)
            2'd1: begin
              if (countdown > 0) begin
                rd_r <= {8'h3C, 1'b0, low_knob}; countdown <= countdown - 1;
              end else rd_r <= {8'h3C, 1'b1, low_knob};
            end
            2'd2:    rd_r <= {idcmd, bus_addr[7:0]};
            default: rd_r <= arr_val(bus_addr);
          endcase
        end
      end
    end
  end

  // ---------------- checking ----------------
  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [AW+16:0] exp_e [0:63];
  int             exp_n;
  logic [31:0]    exp_data;
  logic           exp_to;
  logic [7:0]     exp_stat = 8'h00;

  function automatic void add_acc(logic we, logic [AW-1:0] a, logic [15:0] d);
    if (exp_n < 64) exp_e[exp_n] = {we, a, d};
    exp_n++;
  endfunction

  function automatic void exp_poll(int b, logic [6:0] low);
    for (int k = 0; k < 64; k++) begin
      add_acc(1'b1, '0, 16'h0070);
      add_acc(1'b0, '0, 16'h0);
      if (k >= b) begin exp_stat = {1'b1, low}; break; end
      if (k == MAXP - 1) begin exp_stat = {1'b0, low}; exp_to = 1'b1; break; end
    end
  endfunction

  function automatic void build_exp(int op, logic wide, logic [AW-1:0] a, logic [31:0] d, int b, logic [6:0] low);
    logic [AW-1:0] a2;
    a2 = (a + AW'(2)) & AMASK;
    exp_n = 0; exp_data = 32'h0; exp_to = 1'b0;
    case (op)
      0: begin
        add_acc(1'b1, a, 16'h0040);
        add_acc(1'b1, a, wide ? d[31:16] : d[15:0]);
        exp_poll(b, low);
        if (wide && !exp_to) begin
          add_acc(1'b1, a2, 16'h0040);
          add_acc(1'b1, a2, d[15:0]);
          exp_poll(b, low);
        end
      end
      1: begin
        add_acc(1'b1, a, 16'h0060); add_acc(1'b1, a, 16'h00D0);
        add_acc(1'b1, a, 16'h0020); add_acc(1'b1, a, 16'h00D0);
        exp_poll(b, low);
      end
      2: begin
        add_acc(1'b1, a, 16'h00FF); add_acc(1'b0, a, 16'h0);
        if (wide) begin
          add_acc(1'b1, a2, 16'h00FF); add_acc(1'b0, a2, 16'h0);
          exp_data = {arr_val(a), arr_val(a2)};
        end else exp_data = {16'h0, arr_val(a)};
      end
      3: begin
        add_acc(1'b1, '0, 16'h0070); add_acc(1'b0, '0, 16'h0);
        exp_stat = {1'b1, low};
        exp_data = {16'h0, 8'h3C, 1'b1, low};
      end
      4: add_acc(1'b1, '0, 16'h0050);
      5, 6: begin
        add_acc(1'b1, '0, (op == 5) ? 16'h0090 : 16'h0098);
        add_acc(1'b0, (a << 1) & AMASK, 16'h0);
        exp_data = {16'h0, (op == 5) ? 8'h90 : 8'h98, a[6:0], 1'b0};
      end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(int op, logic wide);
    case (op)
      0: return wide ? "R5" : "R3";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      5, 6: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input int op, input logic wide, input logic [AW-1:0] a, input logic [31:0] d,
                        input int b, input logic [6:0] low, input int lat, input int hold);
    string t;
    int    w;
    logic [31:0] snap;
    t = tag_of(op, wide);
    @(negedge clk);
    b_knob = b; low_knob = low; lat_knob = lat; clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
    build_exp(op, wide, a, d, b, low);
    chk(cmd_ready && !busy, "R1 idle ready", {cmd_ready, busy}, 2'b10);
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_wide = wide; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R1 busy after accept", {busy, cmd_ready}, 2'b10);
    w = 0;
    while (!rsp_valid && w < 3000) begin @(negedge clk); w++; end
    chk(rsp_valid, {t, " response arrives"}, rsp_valid, 1);
    snap = rsp_data;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == snap, "R13 response held", rsp_data, snap);
    end
    chk(rsp_data == exp_data, {t, " data"}, rsp_data, exp_data);
    if (op == 0 || op == 1 || op == 4) chk(rsp_data == 32'h0, "R13 zero data", rsp_data, 0);
    chk(rsp_timeout == exp_to, "R11 timeout flag", rsp_timeout, exp_to);
    chk(status_q == exp_stat, "R4 status byte", status_q, exp_stat);
    chk(log_n == exp_n, {t, " access count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_e[i] == exp_e[i], {t, " access"}, log_e[i], exp_e[i]);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!busy && !rsp_valid, "R1 idle after response", {busy, rsp_valid}, 0);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R14 reset state
    chk(!bus_req && !rsp_valid && !busy && status_q == 8'h00, "R14 reset state",
        {bus_req, rsp_valid, busy, status_q}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !rsp_valid && !busy && status_q == 8'h00, "R14 after reset",
        {bus_req, rsp_valid, busy, status_q}, 0);
    // directed corners
    run_op(0, 1'b0, 24'h000100, 32'h0000BEEF, 0, 7'h11, 0, 0);       // R3
    run_op(0, 1'b1, 24'h000200, 32'hDEADBEEF, 2, 7'h05, 1, 1);       // R5
    run_op(1, 1'b0, 24'h020000, 32'h0, MAXP - 1, 7'h00, 2, 0);       // R6 ready on last poll
    run_op(1, 1'b0, 24'h040000, 32'h0, MAXP, 7'h22, 0, 2);           // R11 timeout
    run_op(0, 1'b1, 24'h000300, 32'h12345678, MAXP + 1, 7'h01, 0, 0); // R11 skip second half
    run_op(2, 1'b1, 24'hFFFFFE, 32'h0, 0, 7'h00, 3, 0);              // R7 wrap
    run_op(2, 1'b0, 24'h001234, 32'h0, 0, 7'h00, 0, 0);              // R7 narrow
    run_op(3, 1'b0, 24'h000000, 32'h0, 0, 7'h4A, 1, 0);              // R8
    run_op(4, 1'b0, 24'h000000, 32'h0, 0, 7'h00, 0, 0);              // R9
    run_op(5, 1'b0, 24'h000001, 32'h0, 0, 7'h00, 0, 0);              // R10
    run_op(6, 1'b0, 24'h000027, 32'h0, 0, 7'h00, 2, 1);              // R10
    run_op(7, 1'b1, 24'h000010, 32'hFFFFFFFF, 0, 7'h00, 0, 0);       // R12
    // constrained random
    for (int n = 0; n < 40; n++) begin
      run_op(int'($urandom % 8), logic'($urandom % 2), AW'($urandom) & ~AW'(1), $urandom,
             int'($urandom % (MAXP + 2)), 7'($urandom), int'($urandom % 4), int'($urandom % 3));
    end
    chk(r2_err == 0, "R2 request held until ack", r2_err, 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000 || finished);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule